// File: doc/BRIEF.md
# Two-Level Page Table Walker

The block turns a 32-bit virtual address into a physical address by walking a two-level page table held in memory. A requester hands it a virtual address, an access kind (read or write) and the base address of the top-level table using a valid/ready handshake. The walker fetches the top-level entry, checks it, then fetches the second-level entry and checks that too. The 4 KB page offset is carried through to the result untouched.

Each walk ends with a one-cycle response carrying either a physical address or a fault code. The code distinguishes a missing second-level table, a missing page and an access the page does not permit. Memory is reached through a simple port that issues one read at a time and accepts its data some cycles later, flagged by a valid strobe. Entries share one format. Bit 0 marks the entry present, bit 1 grants read and bit 2 grants write. Bits 31:12 hold a frame number, which is the second-level table base in a top-level entry and the page frame in a second-level entry.

Top module: `pt_walker`

## Requirements
- R1: `req_ready_o` is high only while the walker is idle, and drops in the cycle after a request is accepted until the response has been given.
- R2: The first read of a walk goes to the latched table base plus 4 × vaddr[31:24]. The second read goes to (top entry bits 31:12 shifted left by 12) plus 4 × vaddr[23:12].
- R3: At most one memory read is outstanding, and `mem_req_o` is a single-cycle strobe for each read.
- R4: A top-level entry with bit 0 clear ends the walk after one read with fault code 01.
- R5: A second-level entry with bit 0 clear ends the walk with fault code 10.
- R6: A read needs bit 1 of the second-level entry and a write needs bit 2. The other bit is ignored. A denied access returns fault code 11.
- R7: A successful walk returns fault code 00 and physical address {second-level entry bits 31:12, vaddr[11:0]}. This holds for the extreme indices 0x00, 0xFF and 0xFFF.
- R8: A faulting response carries physical address 0.
- R9: The table base is sampled when the request is accepted. Changing `root_base_i` later has no effect on that walk.
- R10: Each accepted request produces exactly one `rsp_valid_o` pulse of one cycle, after which the walker is ready again.
- R11: While reset is asserted the walker is ready, issues no read and gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker can accept a request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| root_base_i | input | 32 | Top-level table base, sampled on accept |
| mem_req_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 32 | Memory read byte address |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 32 | Memory read data (entry) |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_paddr_o | output | 32 | Physical address, 0 on fault |
| rsp_fault_o | output | 2 | 00 ok, 01 no table, 10 no page, 11 denied |

## Verification
Two events can coincide. A new request may already be waiting on `req_valid_i` in the very cycle the previous walk raises its response, and `root_base_i` may change in the cycle the top-level read returns. The bench drives requests back to back and swaps the base for an empty table right after acceptance. The scoreboard requires the response to match the walk through the original table. It also requires the next request's first read to target its own top-level entry, and the read counter must show exactly one or two reads per walk.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int unsigned PTE_PRESENT = 0;
  localparam int unsigned PTE_READ    = 1;
  localparam int unsigned PTE_WRITE   = 2;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_TABLE = 2'b01,
    FLT_PAGE  = 2'b10,
    FLT_PERM  = 2'b11
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_L1,
    ST_CHECK_L1,
    ST_READ_L2,
    ST_CHECK_L2,
    ST_DONE
  } walk_state_e;
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int unsigned VA_W       = 32,
  parameter int unsigned PA_W       = 32,
  parameter int unsigned OFF_W      = 12,
  parameter int unsigned L1_IDX_W   = 8,
  parameter int unsigned ENTRY_LOG2 = 2
) (
  input  logic [VA_W-1:0]       vaddr_i,
  input  logic [PA_W-1:0]       root_i,
  input  logic [PA_W-OFF_W-1:0] tbl_frame_i,
  input  logic                  sel_l2_i,
  output logic [PA_W-1:0]       addr_o
);
  localparam int unsigned L2_IDX_W = VA_W - OFF_W - L1_IDX_W;

  logic [L1_IDX_W-1:0] l1_idx;
  logic [L2_IDX_W-1:0] l2_idx;
  logic [PA_W-1:0]     l1_addr, l2_addr;

  assign l1_idx  = vaddr_i[VA_W-1 -: L1_IDX_W];
  assign l2_idx  = vaddr_i[OFF_W +: L2_IDX_W];
  assign l1_addr = root_i + (PA_W'(l1_idx) << ENTRY_LOG2);
  assign l2_addr = {tbl_frame_i, {OFF_W{1'b0}}} + (PA_W'(l2_idx) << ENTRY_LOG2);
  assign addr_o  = sel_l2_i ? l2_addr : l1_addr;
endmodule

// File: rtl/pt_pte_check.sv
module pt_pte_check
  import pt_walker_pkg::*;
#(
  parameter int unsigned PTE_W = 32
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic             last_level_i,
  input  logic             write_i,
  output logic [1:0]       fault_o
);
  logic perm_ok;

  assign perm_ok = write_i ? pte_i[PTE_WRITE] : pte_i[PTE_READ];

  always_comb begin
    if (!pte_i[PTE_PRESENT])
      fault_o = last_level_i ? FLT_PAGE : FLT_TABLE;
    else if (last_level_i && !perm_ok)
      fault_o = FLT_PERM;
    else
      fault_o = FLT_NONE;
  end
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walker_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic [VA_W-1:0]       req_vaddr_i,
  input  logic                  req_write_i,
  input  logic [PA_W-1:0]       root_base_i,
  output logic                  req_ready_o,
  output logic                  mem_req_o,
  input  logic                  mem_rvalid_i,
  input  logic [PA_W-1:0]       mem_rdata_i,
  input  logic [1:0]            chk_fault_i,
  output logic [VA_W-1:0]       vaddr_o,
  output logic [PA_W-1:0]       root_o,
  output logic [PA_W-OFF_W-1:0] tbl_frame_o,
  output logic                  sel_l2_o,
  output logic [PA_W-1:0]       pte_o,
  output logic                  last_level_o,
  output logic                  write_o,
  output logic                  rsp_valid_o,
  output logic [PA_W-1:0]       rsp_paddr_o,
  output logic [1:0]            rsp_fault_o
);
  localparam int unsigned FRAME_W = PA_W - OFF_W;

  walk_state_e         state_q, state_d;
  logic                issued_q;
  logic [VA_W-1:0]     va_q;
  logic [PA_W-1:0]     root_q, pte_q, paddr_q;
  logic [FRAME_W-1:0]  tbl_q;
  logic                write_q;
  logic [1:0]          fault_q;
  logic                reading, accept;

  assign reading = (state_q == ST_READ_L1) || (state_q == ST_READ_L2);
  assign accept  = (state_q == ST_IDLE) && req_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_valid_i) state_d = ST_READ_L1;
      ST_READ_L1:  if (issued_q && mem_rvalid_i) state_d = ST_CHECK_L1;
      ST_CHECK_L1: state_d = (chk_fault_i == FLT_NONE) ? ST_READ_L2 : ST_DONE;
      ST_READ_L2:  if (issued_q && mem_rvalid_i) state_d = ST_CHECK_L2;
      ST_CHECK_L2: state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      issued_q <= 1'b0;
      va_q     <= '0;
      root_q   <= '0;
      pte_q    <= '0;
      tbl_q    <= '0;
      write_q  <= 1'b0;
      paddr_q  <= '0;
      fault_q  <= FLT_NONE;
    end else begin
      state_q <= state_d;
      if (accept) begin
        va_q    <= req_vaddr_i;
        root_q  <= root_base_i;
        write_q <= req_write_i;
        paddr_q <= '0;
        fault_q <= FLT_NONE;
      end
      // one read per READ state; issued_q drops when leaving it
      if (reading && !issued_q) issued_q <= 1'b1;
      else if (reading && mem_rvalid_i) issued_q <= 1'b0;
      if (reading && issued_q && mem_rvalid_i) pte_q <= mem_rdata_i;
      if (state_q == ST_CHECK_L1) begin
        tbl_q <= pte_q[PA_W-1:OFF_W];
        if (chk_fault_i != FLT_NONE) fault_q <= chk_fault_i;
      end
      if (state_q == ST_CHECK_L2) begin
        fault_q <= chk_fault_i;
        if (chk_fault_i == FLT_NONE)
          paddr_q <= {pte_q[PA_W-1:OFF_W], va_q[OFF_W-1:0]};
      end
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign mem_req_o    = reading && !issued_q;
  assign vaddr_o      = va_q;
  assign root_o       = root_q;
  assign tbl_frame_o  = tbl_q;
  assign sel_l2_o     = (state_q == ST_READ_L2);
  assign pte_o        = pte_q;
  assign last_level_o = (state_q == ST_CHECK_L2);
  assign write_o      = write_q;
  assign rsp_valid_o  = (state_q == ST_DONE);
  assign rsp_paddr_o  = paddr_q;
  assign rsp_fault_o  = fault_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int unsigned VA_W       = 32,
  parameter int unsigned PA_W       = 32,
  parameter int unsigned OFF_W      = 12,
  parameter int unsigned L1_IDX_W   = 8,
  parameter int unsigned ENTRY_LOG2 = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [VA_W-1:0] req_vaddr_i,
  input  logic            req_write_i,
  input  logic [PA_W-1:0] root_base_i,
  output logic            mem_req_o,
  output logic [PA_W-1:0] mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [PA_W-1:0] mem_rdata_i,
  output logic            rsp_valid_o,
  output logic [PA_W-1:0] rsp_paddr_o,
  output logic [1:0]      rsp_fault_o
);
  localparam int unsigned FRAME_W = PA_W - OFF_W;

  logic [VA_W-1:0]    va;
  logic [PA_W-1:0]    root, pte;
  logic [FRAME_W-1:0] tbl_frame;
  logic               sel_l2, last_level, write_acc;
  logic [1:0]         chk_fault;

  pt_walk_fsm #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_vaddr_i  (req_vaddr_i),
    .req_write_i  (req_write_i),
    .root_base_i  (root_base_i),
    .req_ready_o  (req_ready_o),
    .mem_req_o    (mem_req_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .chk_fault_i  (chk_fault),
    .vaddr_o      (va),
    .root_o       (root),
    .tbl_frame_o  (tbl_frame),
    .sel_l2_o     (sel_l2),
    .pte_o        (pte),
    .last_level_o (last_level),
    .write_o      (write_acc),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_paddr_o  (rsp_paddr_o),
    .rsp_fault_o  (rsp_fault_o)
  );

  pt_addr_gen #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W),
    .L1_IDX_W(L1_IDX_W), .ENTRY_LOG2(ENTRY_LOG2)
  ) u_addr (
    .vaddr_i     (va),
    .root_i      (root),
    .tbl_frame_i (tbl_frame),
    .sel_l2_i    (sel_l2),
    .addr_o      (mem_addr_o)
  );

  pt_pte_check #(.PTE_W(PA_W)) u_check (
    .pte_i        (pte),
    .last_level_i (last_level),
    .write_i      (write_acc),
    .fault_o      (chk_fault)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned PA_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic            mem_req_o,
  input logic            mem_rvalid_i,
  input logic            rsp_valid_o,
  input logic [PA_W-1:0] rsp_paddr_o,
  input logic [1:0]      rsp_fault_o
);
  logic outst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outst_q <= 1'b0;
    else if (mem_req_o) outst_q <= 1'b1;
    else if (mem_rvalid_i) outst_q <= 1'b0;
  end

  p_ready_drops_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_single_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !outst_q);

  p_strobe_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  p_fault_zero_paddr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o != 2'b00) |-> (rsp_paddr_o == '0));

  p_rsp_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o));

  p_no_ready_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || rsp_valid_o) |-> !req_ready_o);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r11: assert (req_ready_o && !mem_req_o && !rsp_valid_o);
    end
  end
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .mem_req_o    (mem_req_o),
  .mem_rvalid_i (mem_rvalid_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_paddr_o  (rsp_paddr_o),
  .rsp_fault_o  (rsp_fault_o)
);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ROOT_A = 32'h0001_0000;
  localparam logic [31:0] ROOT_B = 32'h0002_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic [31:0] root_base = ROOT_A;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int checks = 0;
  int failures = 0;
  int n_reads = 0;
  int n_rsp = 0;
  bit done = 1'b0;
  logic [31:0] read_log [$];
  logic [31:0] mem [logic [31:0]];

  typedef struct {
    logic [31:0] paddr;
    logic [1:0]  fault;
    string       req;
  } exp_t;
  exp_t exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .req_write_i(req_write), .root_base_i(root_base),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  // memory model: variable latency, one read at a time
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req) begin
        logic [31:0] a;
        int lat;
        a = mem_addr;
        read_log.push_back(a);
        lat = 1 + (n_reads % 3);
        n_reads++;
        repeat (lat) @(negedge clk);
        mem_rdata  = rd(a);
        mem_rvalid = 1'b1;
        @(negedge clk);
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10", "unexpected response", {30'b0, rsp_fault}, 32'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(rsp_fault == e.fault, e.req, "fault", {30'b0, rsp_fault}, {30'b0, e.fault});
          check(rsp_paddr == e.paddr, e.req, "paddr", rsp_paddr, e.paddr);
        end
        n_rsp++;
      end
    end
  end

  // expected walk from the requirement rules
  task automatic model(input logic [31:0] va, input bit wr, input logic [31:0] root,
                       output logic [31:0] pa, output logic [1:0] flt, output int nrd);
    logic [31:0] e1, e2;
    e1 = rd(root + {22'b0, va[31:24], 2'b00});
    pa = '0; nrd = 1;
    if (!e1[0]) begin flt = 2'b01; return; end
    nrd = 2;
    e2 = rd({e1[31:12], 12'b0} + {18'b0, va[23:12], 2'b00});
    if (!e2[0]) flt = 2'b10;
    else if (!(wr ? e2[2] : e2[1])) flt = 2'b11;
    else begin flt = 2'b00; pa = {e2[31:12], va[11:0]}; end
  endtask

  task automatic do_req(input logic [31:0] va, input bit wr, input string req,
                        input bit swap_root);
    exp_t e;
    int rd0, rs0, nrd, t;
    logic [31:0] pa;
    logic [1:0] flt;
    model(va, wr, ROOT_A, pa, flt, nrd);
    e.paddr = pa; e.fault = flt; e.req = req;
    exp_q.push_back(e);
    rd0 = n_reads; rs0 = n_rsp;
    req_vaddr = va; req_write = wr; root_base = ROOT_A; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr = ~va; req_write = ~wr;
    if (swap_root) root_base = ROOT_B; // R9: must not affect this walk
    check(req_ready == 1'b0, "R1", "ready after accept", {31'b0, req_ready}, 32'h0);
    t = 0;
    while (n_rsp == rs0 && t < 200) begin @(negedge clk); t++; end
    check(n_reads - rd0 == nrd, (nrd == 1) ? "R4" : "R3", "read count",
          n_reads - rd0, nrd);
    if (read_log.size() > rd0)
      check(read_log[rd0] == ROOT_A + {22'b0, va[31:24], 2'b00}, "R2", "first read addr",
            read_log[rd0], ROOT_A + {22'b0, va[31:24], 2'b00});
    if (nrd == 2 && read_log.size() > rd0 + 1)
      check(read_log[rd0+1] == {rd(ROOT_A + {22'b0, va[31:24], 2'b00}) >> 12 << 12}
                               + {18'b0, va[23:12], 2'b00},
            "R2", "second read addr", read_log[rd0+1],
            {rd(ROOT_A + {22'b0, va[31:24], 2'b00}) >> 12 << 12} + {18'b0, va[23:12], 2'b00});
    root_base = ROOT_A;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // entry bits: 0 present, 1 read, 2 write, 31:12 frame
    mem[ROOT_A + 32'h12*4] = 32'h0003_0001;
    mem[ROOT_A + 32'hFF*4] = 32'h0004_0001;
    mem[ROOT_A + 32'h00*4] = 32'h0005_0000;        // not present
    mem[32'h0003_0000 + 32'h005*4] = 32'hABCD_E007;
    mem[32'h0003_0000 + 32'h006*4] = 32'h1111_1005; // write only
    mem[32'h0003_0000 + 32'h007*4] = 32'h2222_2003; // read only
    mem[32'h0003_0000 + 32'hFFF*4] = 32'h3333_3003;
    mem[32'h0004_0000 + 32'h000*4] = 32'h4444_4007;

    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R11", "ready in reset", {31'b0, req_ready}, 32'h1);
    check(mem_req == 1'b0, "R11", "mem_req in reset", {31'b0, mem_req}, 32'h0);
    check(rsp_valid == 1'b0, "R11", "rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    do_req(32'h1200_5ABC, 1'b0, "R7", 1'b0);
    do_req(32'h1200_5FFF, 1'b1, "R7", 1'b0);
    do_req(32'h3400_0123, 1'b0, "R4", 1'b0);
    do_req(32'h0000_0FFF, 1'b1, "R4", 1'b0);
    do_req(32'h1200_8000, 1'b0, "R5", 1'b0);
    do_req(32'h1200_6111, 1'b0, "R6", 1'b0);
    do_req(32'h1200_6111, 1'b1, "R6", 1'b0);
    do_req(32'h1200_7222, 1'b1, "R6", 1'b0);
    do_req(32'h1200_7222, 1'b0, "R6", 1'b0);
    do_req(32'h12FF_F000, 1'b0, "R7", 1'b0);
    do_req(32'hFF00_0FFF, 1'b1, "R7", 1'b0);
    do_req(32'h1200_5001, 1'b0, "R9", 1'b1);
    do_req(32'h1200_6ABC, 1'b0, "R8", 1'b1);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R10", "pending responses", exp_q.size(), 32'h0);
    check(req_ready == 1'b1, "R10", "ready when idle", {31'b0, req_ready}, 32'h1);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule